// File: doc/BRIEF.md
# Software Interrupt Request Register with Level Gate

This block keeps a 17-bit register of software-raised interrupt requests together with a 4-bit current interrupt level. It also presents a 17-bit vector to the core that shows which of those requests may be taken at that level. The vector is registered. Every change to the request register or to the level shows up in the vector on the same clock edge that stores the change.

Software changes the request register through three ports, each with its own enable:

- a replace port, which loads a whole new value;
- an OR-in port, which raises every bit that is one in its mask;
- a knock-out port, which drops every bit that is one in its mask.

Two timer event inputs raise the top request bit (bit 16) and the bottom request bit (bit 0). The middle bits 1 to 15 each stand for the interrupt level equal to their index. The level gate passes such a bit only when its index is above the current level. The two end bits share one fixed gate: they pass only while the level is below 14.

Top module: `swirq_gate`

## Requirements
- R1: After reset the request register, the level and the pending vector are all zero.
- R2: A replace write with `rep_we` high loads `rep_data` into the request register. The new value is visible on `req_q_o` after the next rising edge.
- R3: An OR-in write with `or_we` high raises every register bit that is one in `or_mask` and leaves all other bits unchanged.
- R4: A knock-out write with `ko_we` high clears every register bit that is one in `ko_mask` and leaves all other bits unchanged.
- R5: When several software ports are written in the same cycle, they are applied in this order: replace first, then OR-in, then knock-out. The knock-out is applied last among the software ports.
- R6: `tmr_hi_evt` sets register bit 16 and `tmr_lo_evt` sets register bit 0. A timer event wins over a knock-out of the same bit in the same cycle.
- R7: For each bit n from 1 to 15, pending bit n is one exactly when register bit n is one and n is strictly greater than the level.
- R8: Pending bits 0 and 16 are each one exactly when the matching register bit is one and the level is 13 or lower. At level 14 and 15 they are zero.
- R9: A level write with `lvl_we` high stores `lvl_data`. The pending vector is re-evaluated against the new level on the same edge.
- R10: The pending vector is registered. It does not change before the clock edge that follows a write or a timer event.
- R11: Reading `req_q_o` and `lvl_q_o` has no side effects. With no write and no event, the register, the level and the pending vector hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rep_we | input | 1 | Replace write enable |
| rep_data | input | 17 | Value loaded by a replace write |
| or_we | input | 1 | OR-in write enable |
| or_mask | input | 17 | Bits raised by an OR-in write |
| ko_we | input | 1 | Knock-out write enable |
| ko_mask | input | 17 | Bits cleared by a knock-out write |
| lvl_we | input | 1 | Level write enable |
| lvl_data | input | 4 | New interrupt level |
| tmr_hi_evt | input | 1 | Timer match event; sets bit 16 |
| tmr_lo_evt | input | 1 | Timer match event; sets bit 0 |
| req_q_o | output | 17 | Current request register value |
| lvl_q_o | output | 4 | Current interrupt level |
| pend_o | output | 17 | Registered level-gated pending vector |

## Verification
The bench holds the register at all ones and sweeps the level from 0 to 15. A gate that compared with "greater than or equal" instead of "greater than" would pass bit n at level n. A gate that used the index rule on the end bits would drop bit 16 too late and bit 0 at once. The sharpest checks are at levels 13 and 14 for the end bits. The bench also fires a timer event in the same cycle as a knock-out of the same bit; a design with the wrong priority would lose the timer request. Other checks cover a replace, an OR-in and a knock-out in one cycle, which exposes a reordered merge. Finally, the bench samples the pending vector just before the clock edge after each write, which catches a combinational path that would let the vector change early.

// File: rtl/swirq_pkg.sv
package swirq_pkg;

    parameter int SWI_W        = 17;
    parameter int LVL_W        = 4;
    parameter int FIXED_THRESH = 14;

    localparam int TOP_IDX = SWI_W - 1;

    typedef logic [SWI_W-1:0] swi_vec_t;
    typedef logic [LVL_W-1:0] lvl_t;

    typedef struct packed {
        swi_vec_t req;
        lvl_t     lvl;
        swi_vec_t pend;
    } gate_state_t;

endpackage

// File: rtl/swirq_update.sv
module swirq_update
    import swirq_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  swi_vec_t cur_i,
    input  logic     rep_we_i,
    input  swi_vec_t rep_data_i,
    input  logic     or_we_i,
    input  swi_vec_t or_mask_i,
    input  logic     ko_we_i,
    input  swi_vec_t ko_mask_i,
    input  logic     evt_hi_i,
    input  logic     evt_lo_i,
    output swi_vec_t nxt_o
);

    swi_vec_t after_rep;
    swi_vec_t after_or;
    swi_vec_t after_ko;
    swi_vec_t evt_bits;

    // Timer event bits placed at the two ends of the vector
    generate
        for (genvar n = 0; n < SWI_W; n++) begin : g_evt
            if (n == TOP_IDX) begin : g_top
                assign evt_bits[n] = evt_hi_i;
            end else if (n == 0) begin : g_bot
                assign evt_bits[n] = evt_lo_i;
            end else begin : g_mid
                assign evt_bits[n] = 1'b0;
            end
        end
    endgenerate

    // Software ports in fixed order: replace, OR-in, knock-out
    always_comb begin
        after_rep = rep_we_i ? rep_data_i : cur_i;
        after_or  = or_we_i ? (after_rep | or_mask_i) : after_rep;
        after_ko  = ko_we_i ? (after_or & ~ko_mask_i) : after_or;
        nxt_o     = after_ko | evt_bits;
    end

    // The register follows nxt_o one edge later (checked through cur_i)
    AST_OR_RAISES: assert property (@(posedge clk) disable iff (!rst_n)
        (or_we_i && !ko_we_i) |=> ((cur_i & $past(or_mask_i)) == $past(or_mask_i))); // R3

    AST_KO_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        (ko_we_i && !evt_hi_i && !evt_lo_i) |=> ((cur_i & $past(ko_mask_i)) == '0)); // R4

    AST_TMR_HI: assert property (@(posedge clk) disable iff (!rst_n)
        evt_hi_i |=> cur_i[TOP_IDX]); // R6

    AST_TMR_LO: assert property (@(posedge clk) disable iff (!rst_n)
        evt_lo_i |=> cur_i[0]); // R6

endmodule

// File: rtl/swirq_filter.sv
module swirq_filter
    import swirq_pkg::*;
(
    input  swi_vec_t req_i,
    input  lvl_t     lvl_i,
    output swi_vec_t pend_o
);

    logic [31:0] lvl_ext;
    assign lvl_ext = 32'(lvl_i);

    generate
        for (genvar n = 0; n < SWI_W; n++) begin : g_gate
            if (n == 0 || n == TOP_IDX) begin : g_fixed
                assign pend_o[n] = req_i[n] && (lvl_ext < 32'(FIXED_THRESH));
            end else begin : g_indexed
                assign pend_o[n] = req_i[n] && (32'(n) > lvl_ext);
            end
        end
    endgenerate

endmodule

// File: rtl/swirq_gate.sv
module swirq_gate
    import swirq_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 rep_we,
    input  logic [SWI_W-1:0]     rep_data,
    input  logic                 or_we,
    input  logic [SWI_W-1:0]     or_mask,
    input  logic                 ko_we,
    input  logic [SWI_W-1:0]     ko_mask,
    input  logic                 lvl_we,
    input  logic [LVL_W-1:0]     lvl_data,
    input  logic                 tmr_hi_evt,
    input  logic                 tmr_lo_evt,
    output logic [SWI_W-1:0]     req_q_o,
    output logic [LVL_W-1:0]     lvl_q_o,
    output logic [SWI_W-1:0]     pend_o
);

    gate_state_t st_d;
    gate_state_t st_q;
    swi_vec_t    req_nxt;
    swi_vec_t    pend_nxt;

    swirq_update u_update (
        .clk        (clk),
        .rst_n      (rst_n),
        .cur_i      (st_q.req),
        .rep_we_i   (rep_we),
        .rep_data_i (rep_data),
        .or_we_i    (or_we),
        .or_mask_i  (or_mask),
        .ko_we_i    (ko_we),
        .ko_mask_i  (ko_mask),
        .evt_hi_i   (tmr_hi_evt),
        .evt_lo_i   (tmr_lo_evt),
        .nxt_o      (req_nxt)
    );

    // Gate evaluated on the next register and level, so pend_q tracks them
    swirq_filter u_filter (
        .req_i  (req_nxt),
        .lvl_i  (st_d.lvl),
        .pend_o (pend_nxt)
    );

    always_comb begin
        st_d      = st_q;
        st_d.req  = req_nxt;
        st_d.lvl  = lvl_we ? lvl_data : st_q.lvl;
        st_d.pend = pend_nxt;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign req_q_o = st_q.req;
    assign lvl_q_o = st_q.lvl;
    assign pend_o  = st_q.pend;

    AST_PEND_SUBSET: assert property (@(posedge clk) disable iff (!rst_n)
        ((pend_o & ~req_q_o) == '0)); // R7

    AST_ENDS_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
        (32'(lvl_q_o) >= 32'(FIXED_THRESH)) |-> (!pend_o[0] && !pend_o[TOP_IDX])); // R8

    AST_TOP_LEVEL_MID: assert property (@(posedge clk) disable iff (!rst_n)
        (&lvl_q_o) |-> ((pend_o & ~{1'b1, {(SWI_W-2){1'b0}}, 1'b1}) == '0)); // R7

    AST_LVL_STORE: assert property (@(posedge clk) disable iff (!rst_n)
        lvl_we |=> (lvl_q_o == $past(lvl_data))); // R9

    AST_REPLACE: assert property (@(posedge clk) disable iff (!rst_n)
        (rep_we && !or_we && !ko_we && !tmr_hi_evt && !tmr_lo_evt)
            |=> (req_q_o == $past(rep_data))); // R2

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!rep_we && !or_we && !ko_we && !lvl_we && !tmr_hi_evt && !tmr_lo_evt)
            |=> ($stable(req_q_o) && $stable(lvl_q_o) && $stable(pend_o))); // R11

endmodule

// File: tb/sim_swirq_gate.sv
module sim_swirq_gate;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rep_we = 1'b0, or_we = 1'b0, ko_we = 1'b0, lvl_we = 1'b0;
    logic [16:0] rep_data = '0, or_mask = '0, ko_mask = '0;
    logic [3:0]  lvl_data = '0;
    logic        tmr_hi_evt = 1'b0, tmr_lo_evt = 1'b0;
    logic [16:0] req_q_o, pend_o;
    logic [3:0]  lvl_q_o;

    int checks = 0;
    int failures = 0;
    logic [16:0] m_req = '0;
    logic [3:0]  m_lvl = '0;
    logic [16:0] m_pend = '0;

    always #10 clk = ~clk;   // 50 MHz

    swirq_gate u0 (
        .clk(clk), .rst_n(rst_n),
        .rep_we(rep_we), .rep_data(rep_data),
        .or_we(or_we), .or_mask(or_mask),
        .ko_we(ko_we), .ko_mask(ko_mask),
        .lvl_we(lvl_we), .lvl_data(lvl_data),
        .tmr_hi_evt(tmr_hi_evt), .tmr_lo_evt(tmr_lo_evt),
        .req_q_o(req_q_o), .lvl_q_o(lvl_q_o), .pend_o(pend_o)
    );

    function automatic logic [16:0] exp_pend(input logic [16:0] r, input logic [3:0] l);
        logic [16:0] p;
        for (int n = 0; n < 17; n++) begin
            if (n == 0 || n == 16) p[n] = r[n] && (l < 4'd14);
            else                   p[n] = r[n] && (n > int'(l));
        end
        return p;
    endfunction

    task automatic chk(input logic ok, input string req, input logic [16:0] act, input logic [16:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // One cycle of stimulus, model update, and checks of all outputs.
    task automatic step(input logic rw, input logic [16:0] rd, input logic ow, input logic [16:0] om,
                        input logic kw, input logic [16:0] km, input logic lw, input logic [3:0] ld,
                        input logic th, input logic tl, input string req);
        @(negedge clk);
        rep_we = rw; rep_data = rd; or_we = ow; or_mask = om;
        ko_we = kw; ko_mask = km; lvl_we = lw; lvl_data = ld;
        tmr_hi_evt = th; tmr_lo_evt = tl;
        #1;
        chk(pend_o == m_pend, "R10", pend_o, m_pend);
        if (rw) m_req = rd;
        if (ow) m_req = m_req | om;
        if (kw) m_req = m_req & ~km;
        if (th) m_req[16] = 1'b1;
        if (tl) m_req[0] = 1'b1;
        if (lw) m_lvl = ld;
        m_pend = exp_pend(m_req, m_lvl);
        @(negedge clk);
        rep_we = 0; or_we = 0; ko_we = 0; lvl_we = 0; tmr_hi_evt = 0; tmr_lo_evt = 0;
        chk(req_q_o == m_req, req, req_q_o, m_req);
        chk(lvl_q_o == m_lvl, req, {13'd0, lvl_q_o}, {13'd0, m_lvl});
        chk(pend_o == m_pend, req, pend_o, m_pend);
    endtask

    task automatic t_reset;
        chk(req_q_o == '0, "R1", req_q_o, '0);
        chk(lvl_q_o == '0, "R1", {13'd0, lvl_q_o}, '0);
        chk(pend_o == '0, "R1", pend_o, '0);
    endtask

    task automatic t_replace;
        step(1, 17'h1A5A5, 0, 0, 0, 0, 0, 0, 0, 0, "R2");
        step(1, 17'h0F00F, 0, 0, 0, 0, 0, 0, 0, 0, "R2");
        step(1, 17'h00000, 0, 0, 0, 0, 0, 0, 0, 0, "R2");
    endtask

    task automatic t_or_ko;
        step(0, 0, 1, 17'h10003, 0, 0, 0, 0, 0, 0, "R3");
        step(0, 0, 1, 17'h00F00, 0, 0, 0, 0, 0, 0, "R3");
        step(0, 0, 0, 0, 1, 17'h00101, 0, 0, 0, 0, "R4");
        step(0, 0, 0, 0, 1, 17'h1F000, 0, 0, 0, 0, "R4");
    endtask

    task automatic t_merge_order;
        step(1, 17'h0000F, 1, 17'h000F0, 1, 17'h00033, 0, 0, 0, 0, "R5");
        step(1, 17'h1FFFF, 0, 0, 1, 17'h1FFFF, 0, 0, 0, 0, "R5");
        step(0, 0, 1, 17'h00400, 1, 17'h00400, 0, 0, 0, 0, "R5");
    endtask

    task automatic t_timer;
        step(1, 17'h00000, 0, 0, 0, 0, 0, 0, 1, 0, "R6");
        step(0, 0, 0, 0, 0, 0, 0, 0, 0, 1, "R6");
        step(0, 0, 0, 0, 1, 17'h1FFFF, 0, 0, 1, 1, "R6");
        step(0, 0, 0, 0, 1, 17'h10001, 0, 0, 0, 0, "R4");
        step(0, 0, 0, 0, 1, 17'h00001, 0, 0, 0, 1, "R6");
    endtask

    task automatic t_level_sweep;
        step(1, 17'h1FFFF, 0, 0, 0, 0, 0, 0, 0, 0, "R2");
        for (int l = 0; l < 16; l++) begin
            step(0, 0, 0, 0, 0, 0, 1, 4'(l), 0, 0, (l == 13 || l == 14) ? "R8" : "R7");
        end
        step(0, 0, 0, 0, 0, 0, 1, 4'd13, 0, 0, "R9");
        step(0, 0, 0, 0, 0, 0, 1, 4'd5, 0, 0, "R9");
        step(1, 17'h10421, 0, 0, 0, 0, 1, 4'd14, 0, 0, "R9");
    endtask

    task automatic t_idle;
        for (int i = 0; i < 4; i++) begin
            step(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R11");
        end
    endtask

    initial begin : watchdog
        #2000000;
        failures++;
        checks++;
        $display("FAIL watchdog actual=%h expected=%h", 17'h0, 17'h1);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_replace();
        t_or_ko();
        t_merge_order();
        t_timer();
        t_level_sweep();
        t_idle();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule